// File: doc/BRIEF.md
# Dual-Accumulator 24-bit Arithmetic Unit

This block is a signed arithmetic datapath that completes one operation per clock, with no pipelining, on two 24-bit accumulators. A select input names the working accumulator. That accumulator always supplies the first operand and always receives the result. The second operand comes from one of three sources: the other accumulator, the upper half of a 48-bit product input, or a 24-bit operand bus. The result goes through an adder, then a one-bit shifter, then an optional saturation stage. A status set is updated with every operation: negative, zero, overflow, carry, and a sticky saturation bit.

The block only does arithmetic. Logical operations, bit manipulation, the multiplier and instruction decoding are all outside it. A 3-bit opcode and a valid strobe start each operation.

Top module: `acc_alu24`

## Requirements
- R1: When `op_valid` is high with ADD (opcode 0) or SUB (opcode 1), the working accumulator (`acc_sel` 0 = A, 1 = B) takes src+opnd or src−opnd on the next rising edge. The other accumulator is not changed.
- R2: The second operand is chosen by `opnd_sel`: 0 = the other accumulator, 1 = `mult_in[47:24]`, 2 or 3 = `ext_bus`. LOAD (opcode 7) copies that operand into the working accumulator.
- R3: With `sat_en` high, a result that leaves the signed 24-bit range is clamped to 0x7FFFFF if the true value is above that range, or to 0x800000 if it is below. With `sat_en` low, the result wraps modulo 2^24.
- R4: CMP (opcode 2) computes src−opnd and updates the flags. It writes no accumulator.
- R5: NEG (opcode 3) writes −src. ABS (opcode 4) writes |src|. For 0x800000 both set overflow, and both give 0x7FFFFF with saturation or 0x800000 without.
- R6: ASR (opcode 5) writes src shifted right by one with the sign kept, and carry takes bit 0. SHL (opcode 6) writes src shifted left by one, carry takes bit 23, and overflow is set when bits 23 and 22 differ.
- R7: On every valid operation, `flag_n` and `flag_z` are taken from the sign and zero test of the value written (for CMP, the saturated difference). `flag_v` is set when the true result is out of range. `flag_c` is the unsigned carry for ADD, no-borrow for SUB and CMP, src==0 for NEG, and 0 for ABS and LOAD.
- R8: `flag_sv` is set by any valid operation that overflows while `sat_en` is high. It then stays set until a cycle with `clr_sticky` high and no new saturation. A new saturation wins over a clear in the same cycle.
- R9: With `op_valid` low, the accumulators and the N, Z, V and C flags hold their values.
- R10: A synchronous active-high `rst` clears both accumulators and all five flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Starts an operation this cycle |
| op | input | 3 | Opcode: 0 ADD, 1 SUB, 2 CMP, 3 NEG, 4 ABS, 5 ASR, 6 SHL, 7 LOAD |
| acc_sel | input | 1 | Working accumulator: 0 = A, 1 = B |
| opnd_sel | input | 2 | Second operand source |
| sat_en | input | 1 | Enables clamping on overflow |
| clr_sticky | input | 1 | Clears the sticky saturation flag |
| ext_bus | input | 24 | External operand bus |
| mult_in | input | 48 | Product register; upper half is an operand |
| acc_a | output | 24 | Accumulator A |
| acc_b | output | 24 | Accumulator B |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_v | output | 1 | Overflow |
| flag_c | output | 1 | Carry / no-borrow |
| flag_sv | output | 1 | Sticky saturation |

## Verification
The bench builds the unit with its default width, W = 24, so the bench's range limits ±2^23 are the exact clamp points. At this width, integer arithmetic in the bench can compute true results and carries with no truncation. Operand values are drawn with a strong bias toward 0, ±1, 0x7FFFFF and 0x800000. This bias brings the clamp boundaries, the one negation that overflows, and the shift overflow into reach in a few thousand cycles.

// File: rtl/acc_alu24.sv
module acc_alu24 #(
  parameter int W = 24
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  input  logic [2:0]     op,
  input  logic           acc_sel,
  input  logic [1:0]     opnd_sel,
  input  logic           sat_en,
  input  logic           clr_sticky,
  input  logic [W-1:0]   ext_bus,
  input  logic [2*W-1:0] mult_in,
  output logic [W-1:0]   acc_a,
  output logic [W-1:0]   acc_b,
  output logic           flag_n,
  output logic           flag_z,
  output logic           flag_v,
  output logic           flag_c,
  output logic           flag_sv
);
  localparam logic [2:0] ADD = 3'd0, SUB = 3'd1, CMP = 3'd2, NEG = 3'd3,
                         ABS = 3'd4, ASR = 3'd5, SHL = 3'd6, LD  = 3'd7;
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] src, other, opnd, x, y, sh, res;
  logic [W:0]   sum;
  logic         cin, add_v, v, c, pos;

  assign src   = acc_sel ? acc_b : acc_a;
  assign other = acc_sel ? acc_a : acc_b;
  assign opnd  = (opnd_sel == 2'd0) ? other :
                 (opnd_sel == 2'd1) ? mult_in[2*W-1:W] : ext_bus;

  always_comb begin
    x = src; y = '0; cin = 1'b0;
    case (op)
      ADD:      y = opnd;
      SUB, CMP: begin y = ~opnd; cin = 1'b1; end
      NEG:      begin x = '0; y = ~src; cin = 1'b1; end
      ABS:      if (src[W-1]) begin x = '0; y = ~src; cin = 1'b1; end
      LD:       begin x = '0; y = opnd; end
      default:  ;
    endcase
  end

  assign sum   = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign add_v = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);

  always_comb begin
    sh  = sum[W-1:0];
    v   = add_v;
    c   = sum[W];
    pos = ~sum[W-1];
    case (op)
      ASR: begin sh = {sum[W-1], sum[W-1:1]}; c = sum[0]; v = 1'b0; end
      SHL: begin
        sh  = {sum[W-2:0], 1'b0};
        c   = sum[W-1];
        v   = sum[W-1] ^ sum[W-2];
        pos = ~sum[W-1];
      end
      ABS, LD: c = 1'b0;
      default: ;
    endcase
    if (op != SHL) pos = sum[W-1];
  end

  assign res = (sat_en && v) ? (pos ? MAXP : MINN) : sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_a <= '0; acc_b <= '0;
      flag_n <= 1'b0; flag_z <= 1'b0; flag_v <= 1'b0; flag_c <= 1'b0;
      flag_sv <= 1'b0;
    end else begin
      if (op_valid) begin
        if (op != CMP) begin
          if (acc_sel) acc_b <= res;
          else         acc_a <= res;
        end
        flag_n <= res[W-1];
        flag_z <= (res == '0);
        flag_v <= v;
        flag_c <= c;
      end
      if (op_valid && sat_en && v) flag_sv <= 1'b1;
      else if (clr_sticky)         flag_sv <= 1'b0;
    end
  end
endmodule

module acc_alu24_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst,
  input logic         op_valid,
  input logic [2:0]   op,
  input logic         acc_sel,
  input logic         sat_en,
  input logic         clr_sticky,
  input logic [W-1:0] acc_a,
  input logic [W-1:0] acc_b,
  input logic         flag_n,
  input logic         flag_z,
  input logic         flag_v,
  input logic         flag_c,
  input logic         flag_sv
);
  p_other_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !acc_sel) |=> $stable(acc_b));
  p_other_hold_b_r1: assert property (@(posedge clk) disable iff (rst)
    (op_valid && acc_sel) |=> $stable(acc_a));
  p_clamp_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && sat_en && op != 3'd2 && !acc_sel) |=>
      (!flag_v || acc_a == {1'b0, {(W-1){1'b1}}} || acc_a == {1'b1, {(W-1){1'b0}}}));
  p_cmp_nowrite_r4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 3'd2) |=> ($stable(acc_a) && $stable(acc_b)));
  p_zero_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op != 3'd2 && !acc_sel) |=> (flag_z == (acc_a == '0) && flag_n == acc_a[W-1]));
  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_sv && !clr_sticky) |=> flag_sv);
  p_sticky_set_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && sat_en) |=> (!flag_v || flag_sv));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(acc_a) && $stable(acc_b) && $stable(flag_n) &&
                   $stable(flag_z) && $stable(flag_v) && $stable(flag_c)));
  p_reset_r10: assert property (@(posedge clk)
    rst |=> (acc_a == '0 && acc_b == '0 && !flag_n && !flag_z && !flag_v && !flag_c && !flag_sv));
endmodule

bind acc_alu24 acc_alu24_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .acc_sel(acc_sel),
  .sat_en(sat_en), .clr_sticky(clr_sticky), .acc_a(acc_a), .acc_b(acc_b),
  .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
  .flag_sv(flag_sv)
);

// File: tb/acc_alu24_tb.sv
`timescale 1ns/1ps
module acc_alu24_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic op_valid = 1'b0, acc_sel = 1'b0, sat_en = 1'b0, clr_sticky = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [1:0]  opnd_sel = 2'd0;
  logic [23:0] ext_bus = '0;
  logic [47:0] mult_in = '0;
  logic [23:0] acc_a, acc_b;
  logic flag_n, flag_z, flag_v, flag_c, flag_sv;

  int total = 0, bad = 0;
  logic [23:0] ma = '0, mb = '0;
  logic mn = 0, mz = 0, mv = 0, mc = 0, msv = 0;

  always #2.5 clk = ~clk;

  acc_alu24 u_dut (.clk(clk), .rst(rst), .op_valid(op_valid), .op(op),
    .acc_sel(acc_sel), .opnd_sel(opnd_sel), .sat_en(sat_en),
    .clr_sticky(clr_sticky), .ext_bus(ext_bus), .mult_in(mult_in),
    .acc_a(acc_a), .acc_b(acc_b), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c), .flag_sv(flag_sv));

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint sx(logic [23:0] v);
    return v[23] ? longint'(v) - 64'sd16777216 : longint'(v);
  endfunction

  function automatic string op_tag(logic [2:0] o);
    case (o)
      3'd0, 3'd1: return "R1";
      3'd2:       return "R4";
      3'd3, 3'd4: return "R5";
      3'd5, 3'd6: return "R6";
      default:    return "R2";
    endcase
  endfunction

  task automatic model;
    logic [23:0] s, b, r;
    longint t, ts, tb;
    logic ov, cy;
    if (rst) begin
      ma = '0; mb = '0; {mn, mz, mv, mc, msv} = '0;
      return;
    end
    if (!op_valid) begin
      if (clr_sticky) msv = 0;
      return;
    end
    s = acc_sel ? mb : ma;
    b = (opnd_sel == 0) ? (acc_sel ? ma : mb) : (opnd_sel == 1) ? mult_in[47:24] : ext_bus;
    ts = sx(s); tb = sx(b); cy = 0;
    case (op)
      3'd0: begin t = ts + tb; cy = (longint'(s) + longint'(b)) > 64'sd16777215; end
      3'd1, 3'd2: begin t = ts - tb; cy = (s >= b); end
      3'd3: begin t = -ts; cy = (s == 0); end
      3'd4: t = (ts < 0) ? -ts : ts;
      3'd5: begin t = ts >>> 1; cy = s[0]; end
      3'd6: begin t = ts * 2; cy = s[23]; end
      default: t = tb;
    endcase
    ov = (t > 64'sd8388607) || (t < -64'sd8388608);
    if (ov && sat_en) r = (t > 0) ? 24'h7FFFFF : 24'h800000;
    else r = t[23:0];
    if (op != 3'd2) begin
      if (acc_sel) mb = r; else ma = r;
    end
    mn = r[23]; mz = (r == 0); mv = ov; mc = cy;
    if (ov && sat_en) msv = 1; else if (clr_sticky) msv = 0;
  endtask

  task automatic step(logic v, logic [2:0] o, logic sel, logic [1:0] os,
                      logic sat, logic clr, logic [23:0] bus, logic [23:0] mh);
    string t;
    op_valid = v; op = o; acc_sel = sel; opnd_sel = os; sat_en = sat;
    clr_sticky = clr; ext_bus = bus; mult_in = {mh, 24'h5A5A5A};
    t = rst ? "R10" : (!v ? "R9" : op_tag(o));
    model();
    @(negedge clk);
    chk({t, " acc_a"}, acc_a, ma);
    chk({t, " acc_b"}, acc_b, mb);
    chk({rst ? "R10" : (!v ? "R9" : "R7"), " flags"},
        {flag_n, flag_z, flag_v, flag_c}, {mn, mz, mv, mc});
    chk({rst ? "R10" : "R8", " sticky"}, flag_sv, msv);
  endtask

  function automatic logic [23:0] pick;
    case ($urandom_range(0, 7))
      0: return 24'h000000;
      1: return 24'h000001;
      2: return 24'hFFFFFF;
      3: return 24'h7FFFFF;
      4: return 24'h800000;
      5: return 24'h400000;
      default: return 24'($urandom);
    endcase
  endfunction

  initial begin
    #50000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(1, 3'd7, 0, 2, 0, 0, 24'h123456, 0);      // R10 reset state
    rst = 0;
    step(1, 3'd7, 0, 2, 0, 0, 24'h7FFFF0, 0);      // R2 load from bus
    step(1, 3'd7, 1, 1, 0, 0, 0, 24'h000020);      // R2 load from product upper half
    step(1, 3'd0, 0, 0, 1, 0, 0, 0);               // R3 clamp high, R8 sticky
    step(1, 3'd0, 0, 0, 0, 0, 0, 0);               // R3 wrap
    step(0, 3'd0, 0, 0, 0, 0, 0, 0);               // R9 idle, sticky held
    step(0, 3'd0, 0, 0, 0, 1, 0, 0);               // R8 clear
    step(1, 3'd7, 0, 2, 0, 0, 24'h800000, 0);
    step(1, 3'd3, 0, 0, 1, 0, 0, 0);               // R5 NEG of min, sat
    step(1, 3'd7, 0, 2, 0, 0, 24'h800000, 0);
    step(1, 3'd4, 0, 0, 0, 0, 0, 0);               // R5 ABS of min, wraps
    step(1, 3'd1, 0, 2, 1, 1, 24'h000001, 0);      // R1 sub underflow clamp, R8 set wins
    step(1, 3'd2, 1, 0, 0, 0, 0, 0);               // R4 compare
    step(1, 3'd5, 0, 0, 0, 0, 0, 0);               // R6 asr
    step(1, 3'd6, 1, 0, 1, 0, 0, 0);               // R6 shl
    for (int i = 0; i < 3000; i++) begin
      rst = ($urandom_range(0, 199) == 0);
      step($urandom_range(0, 9) != 0, 3'($urandom), 1'($urandom), 2'($urandom),
           1'($urandom), $urandom_range(0, 9) == 0, pick(), pick());
    end
    rst = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule